// File: doc/BRIEF.md
# Self-Clearing Reset Control Register

This block is a single control word that lets a host start three independent resets: one for the port A PHY, one for the port B PHY, and one for the core logic. A host write that sets one of the three low bits starts a timed reset for that domain. The bit reads back as 1 for as long as the reset output is asserted. It clears by itself on the same cycle that the output is released. A bit that reads 1 cannot be written, so a running reset can be neither extended nor cut short.

The PHY reset is held for a minimum time given in nanoseconds. A counter derives the cycle count from the clock frequency parameter and rounds it up, so the minimum is always met. The core reset leaves both PHY resets running. It has its own hold length. When the core reset begins, the block pulses an abort to the configuration loader. When the core reset ends, it pulses a reload request. Writes that come from the loader's register-initialization path never touch these bits, so a reload cannot start a PHY reset.

Top module: `selfclr_rst_reg`

## Requirements
- R1: While `rst_n` is low, and after it rises with no writes, every output is 0 and `rd_data` reads 0. Driving `rst_n` low during a running reset ends that reset at once.
- R2: Bit 2 controls port B, bit 1 controls port A and bit 0 controls the core. `rd_data` is {29'b0, port B busy, port A busy, core busy}. Bits 31:3 always read 0, and writing them has no effect. One write can start several resets together.
- R3: A host write with bit 1 set, made while port A is idle, asserts `phy_a_rst`. From the cycle after the write, bit 1 reads 1. Both hold for exactly ceil(PHY_HOLD_NS*CLK_HZ/1e9) cycles and then drop in the same cycle.
- R4: Port B behaves the same way through bit 2 and `phy_b_rst`, independently of port A.
- R5: While a bit reads 1, any write to it is ignored. Writing 1 again does not extend the reset.
- R6: Writing 0 starts nothing. A write with `wr_from_loader`=1 changes none of the three bits.
- R7: A host write with bit 0 set asserts `core_rst` for exactly CORE_HOLD cycles, and bit 0 reads 1 for that time. A PHY reset that is already running is neither cleared nor shortened by it.
- R8: `loader_abort` is a one-cycle pulse in the first cycle that `core_rst` is asserted, and occurs at no other time.
- R9: `loader_reload` is a one-cycle pulse in the first cycle after `core_rst` is released, and occurs at no other time. It starts no PHY reset.
- R10: While `core_rst` is asserted, all writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_from_loader | input | 1 | 1 when the write comes from the configuration loader |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Register readback |
| phy_a_rst | output | 1 | Port A PHY reset, active high |
| phy_b_rst | output | 1 | Port B PHY reset, active high |
| core_rst | output | 1 | Core logic reset, active high |
| loader_abort | output | 1 | One-cycle pulse that ends any loader command in progress |
| loader_reload | output | 1 | One-cycle pulse that requests a configuration reload |

## Verification
The bench uses a non-integer hold so that it can measure the rounding exactly. A design that truncates would release the PHY one cycle early. It rewrites a bit while that bit is busy, which exposes a design that restarts its counter and stretches the pulse. It also sends loader-sourced writes, which a design that ignores the source tag would turn into PHY resets. It starts a core reset in the middle of a PHY reset and checks three things: the PHY pulse keeps its full length, the abort falls on the first core-reset cycle, and the reload falls on the first cycle after release. A design that clears everything on a core reset, or misplaces either pulse by a cycle, fails these checks.

// File: rtl/selfclr_rst_reg.sv
module selfclr_rst_reg #(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned PHY_HOLD_NS = 102_000,
  parameter int unsigned CORE_HOLD   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_from_loader,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        phy_a_rst,
  output logic        phy_b_rst,
  output logic        core_rst,
  output logic        loader_abort,
  output logic        loader_reload
);
  localparam longint unsigned HOLD_PROD = longint'(PHY_HOLD_NS) * longint'(CLK_HZ);
  localparam longint unsigned NS_PER_S  = 64'd1_000_000_000;
  localparam int unsigned PHY_HOLD = int'((HOLD_PROD + NS_PER_S - 64'd1) / NS_PER_S);
  localparam int PW = $clog2(PHY_HOLD + 1);
  localparam int CW = $clog2(CORE_HOLD + 1);

  logic          core_busy;
  logic [CW-1:0] core_cnt;
  logic [1:0]    phy_busy;
  logic          host_wr;
  logic          unused_hi;

  assign host_wr   = wr_en & ~wr_from_loader & ~core_busy;
  assign unused_hi = ^wr_data[31:3];

  for (genvar i = 0; i < 2; i++) begin : g_phy
    logic [PW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        phy_busy[i] <= 1'b0;
        cnt         <= '0;
      end else if (phy_busy[i]) begin
        if (cnt == '0) phy_busy[i] <= 1'b0;
        else           cnt         <= cnt - 1'b1;
      end else if (host_wr && wr_data[i+1]) begin
        phy_busy[i] <= 1'b1;
        cnt         <= PW'(PHY_HOLD - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_busy     <= 1'b0;
      core_cnt      <= '0;
      loader_abort  <= 1'b0;
      loader_reload <= 1'b0;
    end else begin
      loader_abort  <= 1'b0;
      loader_reload <= 1'b0;
      if (core_busy) begin
        if (core_cnt == '0) begin
          core_busy     <= 1'b0;
          loader_reload <= 1'b1;
        end else begin
          core_cnt <= core_cnt - 1'b1;
        end
      end else if (host_wr && wr_data[0]) begin
        core_busy    <= 1'b1;
        core_cnt     <= CW'(CORE_HOLD - 1);
        loader_abort <= 1'b1;
      end
    end
  end

  assign phy_a_rst = phy_busy[0];
  assign phy_b_rst = phy_busy[1];
  assign core_rst  = core_busy;
  assign rd_data   = {29'b0, phy_busy[1], phy_busy[0], core_busy};
endmodule

module selfclr_rst_reg_chk #(
  parameter int unsigned PHY_HOLD  = 2,
  parameter int unsigned CORE_HOLD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_from_loader,
  input logic [1:0] wr_sel,
  input logic       phy_a_rst,
  input logic       phy_b_rst,
  input logic       core_rst,
  input logic       loader_abort,
  input logic       loader_reload
);
  logic [31:0] a_run, b_run, c_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_run <= '0;
      b_run <= '0;
      c_run <= '0;
    end else begin
      a_run <= phy_a_rst ? a_run + 1 : '0;
      b_run <= phy_b_rst ? b_run + 1 : '0;
      c_run <= core_rst  ? c_run + 1 : '0;
    end
  end

  p_a_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_a_rst) |-> a_run == 32'(PHY_HOLD));
  p_b_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_b_rst) |-> b_run == 32'(PHY_HOLD));
  p_core_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> c_run == 32'(CORE_HOLD));
  p_a_host_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_a_rst) |-> $past(wr_en && !wr_from_loader && wr_sel[0]));
  p_b_host_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_b_rst) |-> $past(wr_en && !wr_from_loader && wr_sel[1]));
  p_abort_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> loader_abort);
  p_abort_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loader_abort |-> $rose(core_rst));
  p_reload_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> loader_reload);
  p_reload_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loader_reload |-> $fell(core_rst));
  p_core_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phy_a_rst) || $rose(phy_b_rst)) |-> !$past(core_rst));
endmodule

bind selfclr_rst_reg selfclr_rst_reg_chk #(.PHY_HOLD(PHY_HOLD), .CORE_HOLD(CORE_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_from_loader(wr_from_loader),
  .wr_sel(wr_data[2:1]), .phy_a_rst(phy_a_rst), .phy_b_rst(phy_b_rst),
  .core_rst(core_rst), .loader_abort(loader_abort), .loader_reload(loader_reload));

// File: tb/selfclr_rst_reg_test.sv
`timescale 1ns/1ps
module selfclr_rst_reg_test;
  localparam int EXP_PHY  = 61;
  localparam int EXP_CORE = 12;
  localparam int NV = 15;
  // {loader, wdata[3:0], wait[7:0], expected rd[2:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 4'b0000, 8'd1,  3'b000},
    {1'b0, 4'b1000, 8'd1,  3'b000},
    {1'b1, 4'b0110, 8'd1,  3'b000},
    {1'b0, 4'b0010, 8'd1,  3'b010},
    {1'b0, 4'b0100, 8'd1,  3'b110},
    {1'b0, 4'b0000, 8'd1,  3'b110},
    {1'b0, 4'b0010, 8'd50, 3'b110},
    {1'b0, 4'b0000, 8'd8,  3'b110},
    {1'b0, 4'b0000, 8'd1,  3'b100},
    {1'b0, 4'b0000, 8'd1,  3'b000},
    {1'b1, 4'b0001, 8'd1,  3'b000},
    {1'b0, 4'b0001, 8'd1,  3'b001},
    {1'b0, 4'b0110, 8'd5,  3'b001},
    {1'b0, 4'b0000, 8'd6,  3'b001},
    {1'b0, 4'b0000, 8'd1,  3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_from_loader = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic phy_a_rst, phy_b_rst, core_rst, loader_abort, loader_reload;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  selfclr_rst_reg #(.CLK_HZ(200_000_000), .PHY_HOLD_NS(302), .CORE_HOLD(EXP_CORE)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_from_loader(wr_from_loader),
    .wr_data(wr_data), .rd_data(rd_data), .phy_a_rst(phy_a_rst), .phy_b_rst(phy_b_rst),
    .core_rst(core_rst), .loader_abort(loader_abort), .loader_reload(loader_reload));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {27'b0, phy_b_rst, phy_a_rst, core_rst, loader_abort, loader_reload};
  endfunction

  task automatic wr(input logic ldr, input logic [31:0] d);
    wr_en = 1'b1; wr_from_loader = ldr; wr_data = d;
  endtask

  task automatic tick();
    @(negedge clk);
    wr_en = 1'b0; wr_from_loader = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n, na;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 32'h0);
    chk("R1 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after reset", outs(), 32'h0);
    chk("R1 rd_data after reset", rd_data, 32'h0);

    // Vector walk: R2 R5 R6 R10
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][15], {28'b0, VEC[i][14:11]});
      for (int w = 0; w < int'(VEC[i][10:3]); w++) tick();
      chk($sformatf("R2/R5/R6/R10 vector %0d", i), rd_data, {29'b0, VEC[i][2:0]});
    end
    repeat (5) tick();

    // R3: exact port A hold
    wr(1'b0, 32'h2); tick();
    chk("R3 bit1 reads 1", rd_data, 32'h2);
    n = 0;
    while (phy_a_rst && n < 1000) begin n++; tick(); end
    chk("R3 port A hold cycles", n, EXP_PHY);
    chk("R3 bit1 cleared", rd_data, 32'h0);

    // R4: exact port B hold
    wr(1'b0, 32'h4); tick();
    chk("R4 bit2 reads 1", rd_data, 32'h4);
    n = 0;
    while (phy_b_rst && n < 1000) begin n++; tick(); end
    chk("R4 port B hold cycles", n, EXP_PHY);

    // R7/R8/R9: core reset during a port A reset
    wr(1'b0, 32'h2); tick(); na = 1;
    repeat (4) begin tick(); if (phy_a_rst) na++; end
    wr(1'b0, 32'h1); tick(); if (phy_a_rst) na++;
    chk("R8 abort in first core cycle", {core_rst, loader_abort}, 2'b11);
    chk("R7 port A kept at core start", phy_a_rst, 1'b1);
    n = 1;
    tick(); if (phy_a_rst) na++;
    chk("R8 abort single cycle", loader_abort, 1'b0);
    while (core_rst && n < 1000) begin n++; tick(); if (phy_a_rst) na++; end
    chk("R7 core hold cycles", n, EXP_CORE);
    chk("R9 reload after release", loader_reload, 1'b1);
    chk("R7 port A survives core reset", phy_a_rst, 1'b1);
    tick(); if (phy_a_rst) na++;
    chk("R9 reload single cycle, no PHY B", {loader_reload, phy_b_rst}, 2'b00);
    while (phy_a_rst && na < 1000) begin tick(); if (phy_a_rst) na++; end
    chk("R7 port A full hold across core", na, EXP_PHY);
    tick();

    // R2: one write starts all three
    wr(1'b0, 32'hFFFF_FFFF); tick();
    chk("R2 all three set, high bits zero", rd_data, 32'h7);
    repeat (70) tick();
    chk("R2 all cleared", rd_data, 32'h0);

    // R1: reset mid pulse
    wr(1'b0, 32'h4); repeat (3) tick();
    rst_n = 1'b0; #1;
    chk("R1 reset aborts pulse", outs(), 32'h0);
    tick(); rst_n = 1'b1; tick();
    chk("R1 idle after reset", rd_data, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule